// File: doc/BRIEF.md
# Shared Reservation Station Dispatch Pool

This block is the wakeup-and-select stage between a reorder buffer and a set of pipelined execution units. A small pool of reservation stations is shared by every unit class. Instructions whose operands are all present ask for a station through a set of request lanes. At most two requests are granted per cycle, oldest first by reorder-buffer age. Each granted instruction waits in its station until a unit of its class can accept it. It then enters that unit's internal pipeline and its station becomes free.

Finished results leave over one result bus, one per cycle, oldest first. The pool also watches that bus: a request whose missing operand is being written on the bus in the same cycle counts as ready and captures the value. The execution units are latency models. Each one carries the reorder-buffer tag and a stand-in result through a pipeline as deep as its latency. A unit whose result loses the bus holds it in its last stage and backs up behind it.

Top module: `rsp_pool`

## Requirements
- R1: After reset the result bus is idle (`cdb_valid` low), no grant is given while no lane requests, and all four stations are free.
- R2: At most two lanes are granted per cycle, and a lane is granted only when `req_valid` is high and each of its operands is either marked ready or forwarded per R5; `req_grant` is combinational in the requesting cycle and the station is filled at the next rising edge.
- R3: When more lanes are eligible than can be granted, the grants go to the smallest ages, where age = (`req_rob` − `rob_head`) modulo 2^ROBW.
- R4: A grant needs a station that is free at the start of the cycle; a station freed by an issue at an edge can be granted from the following cycle on, so with three stations busy only one grant is given.
- R5: A lane operand that is not ready but whose tag equals `cdb_tag` while `cdb_valid` is high counts as ready in that cycle, and the station captures `cdb_value` for it.
- R6: Operation class codes are 0 integer, 1 FP add, 2 FP multiply, 3 FP divide; with its unit and the bus free, a result appears on the bus 2, 3, 4 or 6 rising edges after the grant edge respectively.
- R7: There is one integer unit, two add units, two multiply units and one divide unit; each accepts one instruction per cycle, a station keeps its instruction until a unit of its class accepts it, and among stations of one class the oldest issues first.
- R8: Only one result uses the bus per cycle, the oldest by age; a result that loses stays in its unit's last stage unchanged and is offered again in the next cycle.
- R9: The result value is a+b for class 0, a−b for class 1, the low 16 bits of a·b for class 2 and a XOR b for class 3 (16-bit operands).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rob_head | input | 3 | Reorder-buffer head index, reference for ages |
| req_valid | input | 4 | Per-lane request |
| req_cls | input | 8 | Per-lane class, lane l at bits [2l+1:2l] |
| req_rob | input | 12 | Per-lane reorder-buffer tag, lane l at [3l+2:3l] |
| req_a | input | 64 | Per-lane first operand, lane l at [16l+15:16l] |
| req_a_rdy | input | 4 | Per-lane first operand present |
| req_a_tag | input | 12 | Per-lane producer tag of the first operand |
| req_b | input | 64 | Per-lane second operand |
| req_b_rdy | input | 4 | Per-lane second operand present |
| req_b_tag | input | 12 | Per-lane producer tag of the second operand |
| req_grant | output | 4 | Per-lane grant |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | 3 | Tag of the result on the bus |
| cdb_value | output | 16 | Value of the result on the bus |

## Verification
The bench builds the pool with its default parameters: four lanes, four stations, a 3-bit tag, 16-bit data and the unit mix and latencies of R6 and R7. With those values a third busy station is reachable within three cycles of back-to-back integer requests, so the single-grant limit shows up. Two add instructions granted together finish in the same cycle and force the bus stall. Two divides granted together must share the lone divider. The 3-bit tag lets a nonzero head wrap the age order.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_FADD = 2'd1,
    CLS_FMUL = 2'd2,
    CLS_FDIV = 2'd3
  } cls_e;

endpackage

// File: rtl/rsp_alloc.sv
// Picks up to GRANTS oldest eligible lanes and binds each to a free station.
module rsp_alloc #(
  parameter int NREQ   = 4,
  parameter int NRS    = 4,
  parameter int ROBW   = 3,
  parameter int GRANTS = 2,
  localparam int LW    = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic [NREQ-1:0]           elig,
  input  logic [NREQ-1:0][ROBW-1:0] age,
  input  logic [NRS-1:0]            busy,
  output logic [NREQ-1:0]           grant,
  output logic [NRS-1:0]            st_load,
  output logic [NRS-1:0][LW-1:0]    st_lane
);

  always_comb begin
    logic [NREQ-1:0] picked;
    logic [NRS-1:0]  taken;
    logic            lfound;
    logic            sfound;
    logic [LW-1:0]   best;
    int              sidx;
    picked  = '0;
    taken   = '0;
    st_load = '0;
    st_lane = '0;
    for (int g = 0; g < GRANTS; g++) begin
      lfound = 1'b0;
      best   = '0;
      for (int l = 0; l < NREQ; l++) begin
        if (elig[l] && !picked[l] && (!lfound || age[l] < age[best])) begin
          lfound = 1'b1;
          best   = LW'(l);
        end
      end
      sfound = 1'b0;
      sidx   = 0;
      for (int s = 0; s < NRS; s++) begin
        if (!busy[s] && !taken[s] && !sfound) begin
          sfound = 1'b1;
          sidx   = s;
        end
      end
      if (lfound && sfound) begin
        picked[best]  = 1'b1;
        taken[sidx]   = 1'b1;
        st_load[sidx] = 1'b1;
        st_lane[sidx] = best;
      end
    end
    grant = picked;
  end

endmodule

// File: rtl/rsp_exec_pipe.sv
// Latency model of one pipelined unit; the last stage holds while not taken.
module rsp_exec_pipe #(
  parameter int LAT  = 2,
  parameter int ROBW = 3,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [ROBW-1:0] in_rob,
  input  logic [DW-1:0]   in_val,
  output logic            in_ready,
  output logic            out_valid,
  output logic [ROBW-1:0] out_rob,
  output logic [DW-1:0]   out_val,
  input  logic            out_take
);

  logic [LAT-1:0]           v_q, v_d;
  logic [LAT-1:0][ROBW-1:0] rob_q, rob_d;
  logic [LAT-1:0][DW-1:0]   val_q, val_d;
  logic [LAT-1:0]           leave, space;

  // movement: a stage leaves when the one after it has room
  always_comb begin
    logic [LAT-1:0] lv;
    logic [LAT-1:0] sp;
    lv[LAT-1] = v_q[LAT-1] & out_take;
    sp[LAT-1] = !v_q[LAT-1] | out_take;
    for (int i = LAT - 2; i >= 0; i--) begin
      lv[i] = v_q[i] & sp[i+1];
      sp[i] = !v_q[i] | lv[i];
    end
    leave = lv;
    space = sp;
  end

  assign in_ready = space[0];

  always_comb begin
    v_d   = v_q;
    rob_d = rob_q;
    val_d = val_q;
    for (int i = LAT - 1; i >= 1; i--) begin
      if (leave[i-1]) begin
        v_d[i]   = 1'b1;
        rob_d[i] = rob_q[i-1];
        val_d[i] = val_q[i-1];
      end else if (leave[i]) begin
        v_d[i] = 1'b0;
      end
    end
    if (in_valid && space[0]) begin
      v_d[0]   = 1'b1;
      rob_d[0] = in_rob;
      val_d[0] = in_val;
    end else if (leave[0]) begin
      v_d[0] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    rob_q <= rob_d;
    val_q <= val_d;
  end

  assign out_valid = v_q[LAT-1];
  assign out_rob   = rob_q[LAT-1];
  assign out_val   = val_q[LAT-1];

  assert_take_needs_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_take |-> out_valid);

  assert_stalled_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_take) |=> (out_valid && $stable(out_rob) && $stable(out_val)));

endmodule

// File: rtl/rsp_cdb_arb.sv
// Gives the single result bus to the oldest finished unit.
module rsp_cdb_arb #(
  parameter int NU   = 6,
  parameter int ROBW = 3,
  parameter int DW   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ROBW-1:0]        head,
  input  logic [NU-1:0]          fin_valid,
  input  logic [NU-1:0][ROBW-1:0] fin_rob,
  input  logic [NU-1:0][DW-1:0]  fin_val,
  output logic [NU-1:0]          take,
  output logic                   cdb_valid,
  output logic [ROBW-1:0]        cdb_tag,
  output logic [DW-1:0]          cdb_value
);

  always_comb begin
    logic            found;
    int              sel;
    logic [ROBW-1:0] age_u;
    logic [ROBW-1:0] age_s;
    found = 1'b0;
    sel   = 0;
    for (int u = 0; u < NU; u++) begin
      age_u = fin_rob[u] - head;
      age_s = fin_rob[sel] - head;
      if (fin_valid[u] && (!found || age_u < age_s)) begin
        found = 1'b1;
        sel   = u;
      end
    end
    take = '0;
    if (found) take[sel] = 1'b1;
    cdb_valid = found;
    cdb_tag   = fin_rob[sel];
    cdb_value = fin_val[sel];
  end

  assert_one_bus_writer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));

  assert_finished_not_starved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|fin_valid) |-> (take != '0));

endmodule

// File: rtl/rsp_pool.sv
module rsp_pool
  import rsp_pkg::*;
#(
  parameter int NREQ    = 4,
  parameter int NRS     = 4,
  parameter int ROBW    = 3,
  parameter int DW      = 16,
  parameter int GRANTS  = 2,
  parameter int N_INT   = 1,
  parameter int N_FADD  = 2,
  parameter int N_FMUL  = 2,
  parameter int N_FDIV  = 1,
  parameter int LAT_INT  = 2,
  parameter int LAT_FADD = 3,
  parameter int LAT_FMUL = 4,
  parameter int LAT_FDIV = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ROBW-1:0]      rob_head,
  input  logic [NREQ-1:0]      req_valid,
  input  logic [2*NREQ-1:0]    req_cls,
  input  logic [ROBW*NREQ-1:0] req_rob,
  input  logic [DW*NREQ-1:0]   req_a,
  input  logic [NREQ-1:0]      req_a_rdy,
  input  logic [ROBW*NREQ-1:0] req_a_tag,
  input  logic [DW*NREQ-1:0]   req_b,
  input  logic [NREQ-1:0]      req_b_rdy,
  input  logic [ROBW*NREQ-1:0] req_b_tag,
  output logic [NREQ-1:0]      req_grant,
  output logic                 cdb_valid,
  output logic [ROBW-1:0]      cdb_tag,
  output logic [DW-1:0]        cdb_value
);

  localparam int NU = N_INT + N_FADD + N_FMUL + N_FDIV;
  localparam int LW = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam int SW = (NRS > 1) ? $clog2(NRS) : 1;

  function automatic cls_e unit_cls(input int u);
    if (u < N_INT)                        return CLS_INT;
    else if (u < N_INT + N_FADD)          return CLS_FADD;
    else if (u < N_INT + N_FADD + N_FMUL) return CLS_FMUL;
    else                                  return CLS_FDIV;
  endfunction

  function automatic int unit_lat(input int u);
    case (unit_cls(u))
      CLS_INT:  return LAT_INT;
      CLS_FADD: return LAT_FADD;
      CLS_FMUL: return LAT_FMUL;
      default:  return LAT_FDIV;
    endcase
  endfunction

  function automatic logic [DW-1:0] calc(input cls_e c, input logic [DW-1:0] a,
                                         input logic [DW-1:0] b);
    case (c)
      CLS_INT:  return a + b;
      CLS_FADD: return a - b;
      CLS_FMUL: return a * b;
      default:  return a ^ b;
    endcase
  endfunction

  // lane decode with same-cycle bus forwarding
  cls_e [NREQ-1:0]            ln_cls;
  logic [NREQ-1:0][ROBW-1:0]  ln_rob, ln_age;
  logic [NREQ-1:0][DW-1:0]    ln_a, ln_b;
  logic [NREQ-1:0]            ln_aok, ln_bok, ln_elig;

  always_comb begin
    for (int l = 0; l < NREQ; l++) begin
      ln_cls[l]  = cls_e'(req_cls[l*2 +: 2]);
      ln_rob[l]  = req_rob[l*ROBW +: ROBW];
      ln_age[l]  = ln_rob[l] - rob_head;
      ln_aok[l]  = req_a_rdy[l] | (cdb_valid && req_a_tag[l*ROBW +: ROBW] == cdb_tag);
      ln_bok[l]  = req_b_rdy[l] | (cdb_valid && req_b_tag[l*ROBW +: ROBW] == cdb_tag);
      ln_a[l]    = req_a_rdy[l] ? req_a[l*DW +: DW] : cdb_value;
      ln_b[l]    = req_b_rdy[l] ? req_b[l*DW +: DW] : cdb_value;
      ln_elig[l] = req_valid[l] & ln_aok[l] & ln_bok[l];
    end
  end

  // station state
  logic [NRS-1:0]            st_busy_q, st_busy_d;
  cls_e [NRS-1:0]            st_cls_q, st_cls_d;
  logic [NRS-1:0][ROBW-1:0]  st_rob_q, st_rob_d, st_age;
  logic [NRS-1:0][DW-1:0]    st_a_q, st_a_d, st_b_q, st_b_d;
  logic [NRS-1:0]            st_load, st_issue;
  logic [NRS-1:0][LW-1:0]    st_lane;

  rsp_alloc #(.NREQ(NREQ), .NRS(NRS), .ROBW(ROBW), .GRANTS(GRANTS)) u_alloc (
    .elig    (ln_elig),
    .age     (ln_age),
    .busy    (st_busy_q),
    .grant   (req_grant),
    .st_load (st_load),
    .st_lane (st_lane)
  );

  always_comb begin
    for (int s = 0; s < NRS; s++) st_age[s] = st_rob_q[s] - rob_head;
  end

  // unit side
  logic [NU-1:0]            u_in_valid, u_ready, f_valid, take;
  logic [NU-1:0][ROBW-1:0]  u_in_rob, f_rob;
  logic [NU-1:0][DW-1:0]    u_in_val, f_val;

  // issue: each unit takes the oldest waiting station of its class
  always_comb begin
    logic [NRS-1:0] claimed;
    logic           found;
    logic [SW-1:0]  sel;
    claimed    = '0;
    u_in_valid = '0;
    u_in_rob   = '0;
    u_in_val   = '0;
    for (int u = 0; u < NU; u++) begin
      found = 1'b0;
      sel   = '0;
      for (int s = 0; s < NRS; s++) begin
        if (st_busy_q[s] && !claimed[s] && st_cls_q[s] == unit_cls(u) &&
            (!found || st_age[s] < st_age[sel])) begin
          found = 1'b1;
          sel   = SW'(s);
        end
      end
      if (found && u_ready[u]) begin
        claimed[sel]  = 1'b1;
        u_in_valid[u] = 1'b1;
        u_in_rob[u]   = st_rob_q[sel];
        u_in_val[u]   = calc(st_cls_q[sel], st_a_q[sel], st_b_q[sel]);
      end
    end
    st_issue = claimed;
  end

  always_comb begin
    st_busy_d = st_busy_q & ~st_issue;
    st_cls_d  = st_cls_q;
    st_rob_d  = st_rob_q;
    st_a_d    = st_a_q;
    st_b_d    = st_b_q;
    for (int s = 0; s < NRS; s++) begin
      if (st_load[s]) begin
        st_busy_d[s] = 1'b1;
        st_cls_d[s]  = ln_cls[st_lane[s]];
        st_rob_d[s]  = ln_rob[st_lane[s]];
        st_a_d[s]    = ln_a[st_lane[s]];
        st_b_d[s]    = ln_b[st_lane[s]];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_busy_q <= '0;
    else        st_busy_q <= st_busy_d;
  end

  always_ff @(posedge clk) begin
    st_cls_q <= st_cls_d;
    st_rob_q <= st_rob_d;
    st_a_q   <= st_a_d;
    st_b_q   <= st_b_d;
  end

  for (genvar u = 0; u < NU; u++) begin : g_unit
    localparam int LAT_U = unit_lat(u);
    rsp_exec_pipe #(.LAT(LAT_U), .ROBW(ROBW), .DW(DW)) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (u_in_valid[u]),
      .in_rob    (u_in_rob[u]),
      .in_val    (u_in_val[u]),
      .in_ready  (u_ready[u]),
      .out_valid (f_valid[u]),
      .out_rob   (f_rob[u]),
      .out_val   (f_val[u]),
      .out_take  (take[u])
    );
  end

  rsp_cdb_arb #(.NU(NU), .ROBW(ROBW), .DW(DW)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .head      (rob_head),
    .fin_valid (f_valid),
    .fin_rob   (f_rob),
    .fin_val   (f_val),
    .take      (take),
    .cdb_valid (cdb_valid),
    .cdb_tag   (cdb_tag),
    .cdb_value (cdb_value)
  );

  assert_grant_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(req_grant) <= GRANTS);

  assert_grant_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(req_grant) <= $countones(~st_busy_q));

  for (genvar l = 0; l < NREQ; l++) begin : g_lane_chk
    assert_grant_operands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant[l] |-> (req_valid[l] && ln_aok[l] && ln_bok[l]));
  end

  for (genvar s = 0; s < NRS; s++) begin : g_st_chk
    assert_station_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_busy_q[s] && !st_issue[s]) |=> (st_busy_q[s] && $stable(st_rob_q[s])));
  end

endmodule

// File: tb/sim_rsp_pool.sv
`timescale 1ns/100ps
module sim_rsp_pool;
  localparam int NREQ = 4;
  localparam int ROBW = 3;
  localparam int DW   = 16;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [ROBW-1:0]      rob_head;
  logic [NREQ-1:0]      req_valid, req_a_rdy, req_b_rdy, req_grant;
  logic [2*NREQ-1:0]    req_cls;
  logic [ROBW*NREQ-1:0] req_rob, req_a_tag, req_b_tag;
  logic [DW*NREQ-1:0]   req_a, req_b;
  logic                 cdb_valid;
  logic [ROBW-1:0]      cdb_tag;
  logic [DW-1:0]        cdb_value;

  rsp_pool u0 (
    .clk(clk), .rst_n(rst_n), .rob_head(rob_head),
    .req_valid(req_valid), .req_cls(req_cls), .req_rob(req_rob),
    .req_a(req_a), .req_a_rdy(req_a_rdy), .req_a_tag(req_a_tag),
    .req_b(req_b), .req_b_rdy(req_b_rdy), .req_b_tag(req_b_tag),
    .req_grant(req_grant), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .cdb_value(cdb_value)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;

  // bus log
  int lg_tag [256];
  int lg_val [256];
  int lg_cyc [256];
  int lg_n = 0;
  always @(negedge clk) begin
    if (rst_n && cdb_valid && lg_n < 256) begin
      lg_tag[lg_n] = int'(cdb_tag);
      lg_val[lg_n] = int'(cdb_value);
      lg_cyc[lg_n] = cyc;
      lg_n = lg_n + 1;
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic find(input string rc, input string rv, input int base, input int tag,
                      input int exp_cyc, input int exp_val);
    int c = -1;
    int v = -1;
    for (int i = lg_n - 1; i >= base; i--) begin
      if (lg_tag[i] == tag) begin
        c = lg_cyc[i];
        v = lg_val[i];
      end
    end
    chk(rc, c, exp_cyc);
    chk(rv, v, exp_val);
  endtask

  task automatic clear_lanes();
    req_valid = '0; req_cls = '0; req_rob = '0;
    req_a = '0; req_b = '0; req_a_rdy = '1; req_b_rdy = '1;
    req_a_tag = '0; req_b_tag = '0;
  endtask

  task automatic put(input int l, input int c, input int rob, input int a, input int b);
    req_valid[l]             = 1'b1;
    req_cls[l*2 +: 2]        = 2'(c);
    req_rob[l*ROBW +: ROBW]  = ROBW'(rob);
    req_a[l*DW +: DW]        = DW'(a);
    req_b[l*DW +: DW]        = DW'(b);
    req_a_rdy[l]             = 1'b1;
    req_b_rdy[l]             = 1'b1;
  endtask

  task automatic drop(input int l);
    req_valid[l] = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1: idle after reset
  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 bus idle", int'(cdb_valid), 0);
    chk("R1 no grant", int'(req_grant), 0);
  endtask

  // R6 / R9: unobstructed latency and value per class
  task automatic t_latency(input int c, input int lat, input int a, input int b, input int exp);
    int base;
    int k;
    @(negedge clk);
    base = lg_n; k = cyc;
    put(0, c, 1, a, b);
    #1 chk("R2 single grant", int'(req_grant), 1);
    @(negedge clk); clear_lanes();
    wait_n(lat + 3); #1;
    find("R6 latency", "R9 value", base, 1, k + 1 + lat, exp);
  endtask

  // R2 / R3: two oldest of three eligible, unready lane ignored, head wrap
  task automatic t_oldest();
    int base;
    int k;
    rob_head = 3'd0;
    @(negedge clk);
    base = lg_n; k = cyc;
    put(0, 0, 6, 16'h0001, 16'h0001);
    put(1, 0, 2, 16'h0002, 16'h0002);
    put(2, 0, 4, 16'h0004, 16'h0004);
    put(3, 0, 1, 16'h0009, 16'h0009);
    req_a_rdy[3] = 1'b0; req_a_tag[3*ROBW +: ROBW] = 3'd7;
    #1 chk("R3 oldest pair", int'(req_grant), 4'b0110);
    @(negedge clk); drop(1); drop(2);
    #1 chk("R2 unready lane not granted", int'(req_grant), 4'b0001);
    @(negedge clk); clear_lanes();
    wait_n(8); #1;
    find("R7 int order", "R9 int value", base, 2, k + 3, 16'h0004);
    find("R7 int order", "R9 int value", base, 4, k + 4, 16'h0008);
    find("R3 young last", "R9 int value", base, 6, k + 5, 16'h0002);
    rob_head = 3'd5;
    @(negedge clk);
    put(0, 0, 6, 1, 1);
    put(1, 0, 2, 1, 1);
    put(2, 0, 4, 1, 1);
    #1 chk("R3 wrapped age", int'(req_grant), 4'b0011);
    @(negedge clk); clear_lanes();
    wait_n(8);
    rob_head = 3'd0;
  endtask

  // R4: station limit with three busy
  task automatic t_full();
    @(negedge clk);
    put(0, 0, 0, 1, 0); put(1, 0, 1, 1, 0); put(2, 0, 2, 1, 0); put(3, 0, 3, 1, 0);
    #1 chk("R2 two of four", int'(req_grant), 4'b0011);
    @(negedge clk); drop(0); drop(1);
    #1 chk("R4 two free left", int'(req_grant), 4'b1100);
    @(negedge clk); drop(2); drop(3);
    put(0, 0, 4, 1, 0); put(1, 0, 5, 1, 0);
    #1 chk("R4 one free station", int'(req_grant), 4'b0001);
    @(negedge clk); drop(0);
    #1 chk("R4 reuse after issue", int'(req_grant), 4'b0010);
    @(negedge clk); clear_lanes();
    wait_n(10);
  endtask

  // R7 / R8: lone divider and bus collision of two adders
  task automatic t_contention();
    int base;
    int k;
    @(negedge clk);
    base = lg_n; k = cyc;
    put(0, 3, 1, 16'h00FF, 16'h0F0F);
    put(1, 3, 2, 16'hAAAA, 16'h5555);
    #1 chk("R2 two divides", int'(req_grant), 4'b0011);
    @(negedge clk); clear_lanes();
    wait_n(10); #1;
    find("R7 divider first", "R9 div value", base, 1, k + 7, 16'h0FF0);
    find("R7 divider second", "R9 div value", base, 2, k + 8, 16'hFFFF);
    @(negedge clk);
    base = lg_n; k = cyc;
    put(0, 1, 4, 16'h0100, 16'h0001);
    put(1, 1, 3, 16'h0200, 16'h0002);
    #1 chk("R2 two adds", int'(req_grant), 4'b0011);
    @(negedge clk); clear_lanes();
    wait_n(8); #1;
    find("R8 older wins bus", "R9 add value", base, 3, k + 4, 16'h01FE);
    find("R8 loser next cycle", "R8 loser value kept", base, 4, k + 5, 16'h00FF);
  endtask

  // R5: forwarding from the bus in the same cycle
  task automatic t_forward();
    int base;
    int k;
    @(negedge clk);
    base = lg_n; k = cyc;
    put(0, 0, 1, 16'h0100, 16'h0020);
    @(negedge clk); clear_lanes();
    @(negedge clk);
    put(0, 2, 2, 16'hDEAD, 16'h0003);
    req_a_rdy[0] = 1'b0; req_a_tag[0 +: ROBW] = 3'd1;
    #1 chk("R2 waits for operand", int'(req_grant), 0);
    @(negedge clk);
    #1 chk("R5 forwarded grant", int'(req_grant), 1);
    @(negedge clk); clear_lanes();
    wait_n(8); #1;
    find("R6 producer", "R9 producer value", base, 1, k + 3, 16'h0120);
    find("R6 consumer", "R5 captured value", base, 2, k + 8, 16'h0360);
  endtask

  initial begin
    rst_n = 1'b0;
    rob_head = '0;
    clear_lanes();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latency(0, 2, 16'h1234, 16'h0111, 16'h1345);
    t_latency(1, 3, 16'h0500, 16'h0123, 16'h03DD);
    t_latency(2, 4, 16'h0012, 16'h0034, 16'h03A8);
    t_latency(3, 6, 16'hF0F0, 16'h0FF0, 16'hFF00);
    t_oldest();
    t_full();
    t_contention();
    t_forward();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule